// File: doc/BRIEF.md
# Bulk Packet Loopback Client

This block is user logic that sits on a device controller's direct packet port, in the PHY clock domain. The controller streams bulk packet payload to and from the block one byte at a time. The block serves one OUT endpoint and one IN endpoint, both chosen by parameters. It holds a single-packet buffer. A packet received on the OUT endpoint fills the buffer. The buffer is then offered as the payload of the next IN transfer, so a host that writes and then reads sees its own data come back.

For each transfer the block decides readiness and the controller acts on that answer. Readiness low means the controller answers NAK, and stall high means it answers STALL. On receive, the block drops the two trailing check bytes, and it throws the whole packet away if the controller flags an error at the end. On transmit, the block keeps the packet after an error at the end and sends it again from its first byte on the next IN transfer. It frees the buffer only after a clean end.

An OUT packet that is longer than the buffer plus its two check bytes halts the OUT endpoint. The endpoint then answers STALL until reset.

Top module: `usb_pkt_client`

## Requirements
- R1: While rst_ni is low, rdy_o and stall_o are low.
- R2: When act_i rises with ep_i equal to OUT_EP (default 1) and the buffer is empty, rdy_o is high at the first clock edge after that rise. For any endpoint other than OUT_EP or IN_EP (default 2), rdy_o stays low.
- R3: An IN transfer while the buffer is empty gets rdy_o low for its whole duration. An OUT transfer while the buffer is full also gets rdy_o low for its whole duration.
- R4: During an OUT transfer, one byte of dat_i is taken on each clock in which nxt_i and rdy_o are both high. On a clean end, every byte except the last two becomes the buffered payload. A clean end is act_i falling with err_i low in the first low cycle. Full-length payloads of MAX_PKT bytes (default 64) are kept whole.
- R5: An OUT transfer that ends with err_i high leaves the buffer empty.
- R6: During an IN transfer, dat_o presents the next unsent payload byte. After each clock in which nxt_i and rdy_o are both high, dat_o moves to the following byte.
- R7: On an IN transfer, rdy_o falls at the clock edge that takes the last payload byte. For a zero-length payload, rdy_o is high for exactly one cycle.
- R8: An IN transfer that ends with err_i high keeps the buffer. The next IN transfer sends the same bytes again from the first.
- R9: An IN transfer with a clean end empties the buffer, so the next OUT transfer is accepted.
- R10: An OUT packet of more than MAX_PKT+2 bytes that ends cleanly is discarded and halts the OUT endpoint. From then on, OUT transfers see stall_o high and rdy_o low one clock after act_i rises. stall_o is never high for the IN endpoint.
- R11: rdy_o and stall_o are low in every cycle that follows a cycle with act_i low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PHY-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Packet transfer in progress |
| ep_i | input | 3 | Endpoint number, valid while act_i is high |
| nxt_i | input | 1 | A byte moves in this cycle |
| err_i | input | 1 | Transfer error, sampled in the first cycle after act_i falls |
| dat_i | input | 8 | Received byte from the controller |
| dat_o | output | 8 | Byte to transmit to the controller |
| rdy_o | output | 1 | Endpoint ready for this transfer |
| stall_o | output | 1 | Endpoint halted |

## Verification
rdy_o and stall_o come from registers. They answer one clock edge after the inputs that decide them: the rise of act_i, the edge that takes the last byte, and the first cycle with act_i low. dat_o is read combinationally from the buffer, so it moves to the next byte in the cycle after a clock with nxt_i high. The bench drives inputs on falling edges and updates a queue-based reference model on every rising edge. It compares rdy_o, stall_o and, during IN payload, dat_o against the model on each following falling edge, which is where each result is due. Whole-packet comparisons of the echoed payload cover storage, check-byte removal and resend.

// File: rtl/pkt_client_pkg.sv
package pkt_client_pkg;
  typedef enum logic [1:0] {
    SESS_IDLE = 2'd0,
    SESS_RX   = 2'd1,
    SESS_TX   = 2'd2
  } sess_e;
endpackage

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pkt_rx_ctl.sv
module pkt_rx_ctl #(
  parameter int MAX_PKT = 64,
  localparam int AW = $clog2(MAX_PKT),
  localparam int LW = $clog2(MAX_PKT + 1),
  localparam int CW = $clog2(MAX_PKT + 4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          clr_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          ovf_o,
  output logic [LW-1:0] pay_len_o
);
  localparam logic [CW-1:0] CntSat = CW'(MAX_PKT + 3);
  localparam logic [CW-1:0] CntMem = CW'(MAX_PKT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] body;

  // count saturates one past the largest legal packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (take_i && cnt_q < CntSat) cnt_q <= cnt_q + 1'b1;
  end

  assign wr_en_o   = take_i && (cnt_q < CntMem);
  assign wr_addr_o = cnt_q[AW-1:0];
  assign ovf_o     = (cnt_q == CntSat);
  assign body      = (cnt_q < CW'(2)) ? '0 : cnt_q - CW'(2);
  assign pay_len_o = body[LW-1:0];
endmodule

// File: rtl/pkt_tx_ctl.sv
module pkt_tx_ctl #(
  parameter int MAX_PKT = 64,
  localparam int LW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          clr_i,
  input  logic [LW-1:0] len_i,
  output logic [LW-1:0] rd_o,
  output logic          more_o
);
  logic [LW-1:0] rd_q, rd_nxt;

  assign rd_nxt = step_i ? rd_q + 1'b1 : rd_q;

  // clr_i rewinds after a failed send and resets after a good one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (clr_i) rd_q <= '0;
    else            rd_q <= rd_nxt;
  end

  assign rd_o   = rd_q;
  assign more_o = rd_nxt < len_i;
endmodule

// File: rtl/usb_pkt_client.sv
module usb_pkt_client #(
  parameter int MAX_PKT = 64,
  parameter int OUT_EP  = 1,
  parameter int IN_EP   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic [2:0] ep_i,
  input  logic       nxt_i,
  input  logic       err_i,
  input  logic [7:0] dat_i,
  output logic [7:0] dat_o,
  output logic       rdy_o,
  output logic       stall_o
);
  import pkt_client_pkg::*;

  localparam int AW = $clog2(MAX_PKT);
  localparam int LW = $clog2(MAX_PKT + 1);
  localparam logic [2:0] OutE = 3'(OUT_EP);
  localparam logic [2:0] InE  = 3'(IN_EP);

  sess_e         sess_q;
  logic          act_q, full_q, halt_q, zl_q, rdy_q, stall_q;
  logic [LW-1:0] len_q;

  logic          m_out, m_in, ending, take, step;
  logic          rdy_d, stall_d;
  logic          wr_en, ovf, more;
  logic [AW-1:0] wr_addr;
  logic [LW-1:0] pay_len, rd;

  assign m_out  = act_i && (ep_i == OutE);
  assign m_in   = act_i && (ep_i == InE);
  assign ending = act_q && !act_i;
  assign take   = m_out && rdy_q && nxt_i;
  assign step   = m_in && rdy_q && nxt_i;

  pkt_rx_ctl #(.MAX_PKT(MAX_PKT)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .clr_i    (ending),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .ovf_o    (ovf),
    .pay_len_o(pay_len)
  );

  pkt_tx_ctl #(.MAX_PKT(MAX_PKT)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .clr_i (ending && (sess_q == SESS_TX)),
    .len_i (len_q),
    .rd_o  (rd),
    .more_o(more)
  );

  pkt_store #(.DEPTH(MAX_PKT)) u_mem (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(dat_i),
    .rd_addr_i(rd[AW-1:0]),
    .rd_data_o(dat_o)
  );

  // zero-length payload: a single ready cycle, then silence
  always_comb begin
    rdy_d   = 1'b0;
    stall_d = 1'b0;
    if (m_out) begin
      rdy_d   = !full_q && !halt_q;
      stall_d = halt_q;
    end else if (m_in) begin
      if (len_q == '0) rdy_d = full_q && !(zl_q || rdy_q);
      else             rdy_d = full_q && more;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q  <= SESS_IDLE;
      act_q   <= 1'b0;
      full_q  <= 1'b0;
      halt_q  <= 1'b0;
      zl_q    <= 1'b0;
      rdy_q   <= 1'b0;
      stall_q <= 1'b0;
      len_q   <= '0;
    end else begin
      act_q   <= act_i;
      rdy_q   <= rdy_d;
      stall_q <= stall_d;
      if (ending) begin
        sess_q <= SESS_IDLE;
        zl_q   <= 1'b0;
        if (sess_q == SESS_RX && !err_i) begin
          if (ovf) halt_q <= 1'b1;
          else begin
            full_q <= 1'b1;
            len_q  <= pay_len;
          end
        end
        if (sess_q == SESS_TX && !err_i) full_q <= 1'b0;
      end else begin
        if (m_in && rdy_q) zl_q <= 1'b1;
        if (sess_q == SESS_IDLE && rdy_q) begin
          if (m_out)     sess_q <= SESS_RX;
          else if (m_in) sess_q <= SESS_TX;
        end
      end
    end
  end

  assign rdy_o   = rdy_q;
  assign stall_o = stall_q;
endmodule

// File: rtl/usb_pkt_client_chk.sv
module usb_pkt_client_chk #(
  parameter int OUT_EP = 1,
  parameter int IN_EP  = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       act_i,
  input logic [2:0] ep_i,
  input logic       nxt_i,
  input logic [7:0] dat_o,
  input logic       rdy_o,
  input logic       stall_o
);
  localparam logic [2:0] OutE = 3'(OUT_EP);
  localparam logic [2:0] InE  = 3'(IN_EP);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (!rdy_o && !stall_o));

  assert_ready_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> ($past(act_i) && ($past(ep_i) == OutE || $past(ep_i) == InE)));

  assert_stall_out_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ($past(act_i) && $past(ep_i) == OutE));

  assert_stall_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdy_o && stall_o));

  assert_tx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && ep_i == InE && rdy_o && !nxt_i) |=> $stable(dat_o));
endmodule

bind usb_pkt_client usb_pkt_client_chk #(.OUT_EP(OUT_EP), .IN_EP(IN_EP)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .act_i  (act_i),
  .ep_i   (ep_i),
  .nxt_i  (nxt_i),
  .dat_o  (dat_o),
  .rdy_o  (rdy_o),
  .stall_o(stall_o)
);

// File: tb/usb_pkt_client_test.sv
`timescale 1ns/1ps
module usb_pkt_client_test;
  localparam int MAXP = 64;
  localparam logic [2:0] OE = 3'd1;
  localparam logic [2:0] IE = 3'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0, nxt = 1'b0, err = 1'b0;
  logic [2:0] ep = 3'd0;
  logic [7:0] din = 8'd0;
  logic [7:0] dat_o;
  logic rdy_o, stall_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_pkt_client #(.MAX_PKT(MAXP), .OUT_EP(1), .IN_EP(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .ep_i(ep), .nxt_i(nxt),
    .err_i(err), .dat_i(din), .dat_o(dat_o), .rdy_o(rdy_o), .stall_o(stall_o)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // reference model
  byte unsigned m_rx[$];
  byte unsigned m_buf[$];
  bit m_actq, m_full, m_halt, m_zl, m_rdy, m_stall;
  int m_sess, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx.delete(); m_buf.delete();
      m_actq = 0; m_full = 0; m_halt = 0; m_zl = 0; m_rdy = 0; m_stall = 0;
      m_sess = 0; m_rd = 0;
    end else begin
      bit mo, mi, nr, ns;
      mo = act && ep == OE;
      mi = act && ep == IE;
      nr = 0; ns = 0;
      if (act) begin
        if (m_rdy && m_sess == 0) m_sess = mo ? 1 : (mi ? 2 : 0);
        if (m_rdy && mo && nxt) m_rx.push_back(din);
        if (m_rdy && mi && nxt) m_rd++;
        if (mo) begin
          nr = !m_full && !m_halt;
          ns = m_halt;
        end else if (mi) begin
          if (m_buf.size() == 0) nr = m_full && !m_zl && !m_rdy;
          else nr = m_full && m_rd < m_buf.size();
          if (m_rdy) m_zl = 1;
        end
      end
      if (m_actq && !act) begin
        if (m_sess == 1 && !err) begin
          if (m_rx.size() > MAXP + 2) m_halt = 1;
          else begin
            m_buf.delete();
            for (int i = 0; i + 2 < m_rx.size(); i++) m_buf.push_back(m_rx[i]);
            m_full = 1;
          end
        end
        if (m_sess == 2) begin
          m_rd = 0;
          if (!err) m_full = 0;
        end
        m_sess = 0; m_zl = 0; m_rx.delete();
      end
      m_rdy = nr; m_stall = ns; m_actq = act;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdy_o === m_rdy, "R7 rdy_o per clock", int'(rdy_o), int'(m_rdy));
      chk(stall_o === m_stall, "R10 stall_o per clock", int'(stall_o), int'(m_stall));
      if (act && ep == IE && m_rdy && m_rd < m_buf.size())
        chk(dat_o === m_buf[m_rd], "R6 dat_o per clock", int'(dat_o), int'(m_buf[m_rd]));
    end
  end

  task automatic wait_rdy(output bit acc, output bit st);
    @(negedge clk);
    acc = rdy_o; st = stall_o;
    if (!acc) begin
      repeat (2) @(negedge clk);
      acc = rdy_o; st = st | stall_o;
    end
  endtask

  task automatic finish_pkt(input bit bad);
    nxt = 0; act = 0; err = bad; ep = 3'd0;
    @(negedge clk);
    err = 0;
    @(negedge clk);
    chk(!rdy_o && !stall_o, "R11 quiet after end", int'(rdy_o | stall_o), 0);
  endtask

  task automatic pkt_out(input logic [2:0] e, input int n, input int seed, input bit bad,
                         output bit acc, output bit st);
    act = 1; ep = e; nxt = 0;
    wait_rdy(acc, st);
    if (acc) begin
      for (int i = 0; i < n; i++) begin
        if (i % 5 == 3) begin nxt = 0; @(negedge clk); end
        nxt = 1; din = 8'(seed + i * 7);
        @(negedge clk);
      end
    end
    finish_pkt(bad);
  endtask

  task automatic pkt_in(input int exp_len, input bit bad, output bit acc,
                        output int rc, output byte unsigned got[$]);
    bit st;
    int k;
    got.delete(); rc = 0; k = 0;
    act = 1; ep = IE; nxt = 0;
    wait_rdy(acc, st);
    while (rdy_o && k < 300) begin
      rc++;
      nxt = (k % 4 != 2) && (got.size() < exp_len);
      if (nxt) got.push_back(dat_o);
      k++;
      @(negedge clk);
    end
    nxt = 0;
    repeat (4) @(negedge clk);
    finish_pkt(bad);
  endtask

  function automatic bit same(byte unsigned a[$], byte unsigned b[$]);
    if (a.size() != b.size()) return 0;
    foreach (a[i]) if (a[i] != b[i]) return 0;
    return 1;
  endfunction

  function automatic void expect_pay(int n, int seed, ref byte unsigned q[$]);
    q.delete();
    for (int i = 0; i + 2 < n; i++) q.push_back(8'(seed + i * 7));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit acc, st;
    int rc;
    byte unsigned got[$], got2[$], exp[$];

    repeat (3) @(negedge clk);
    chk(!rdy_o && !stall_o, "R1 reset outputs", int'(rdy_o | stall_o), 0);
    rst_n = 1;
    @(negedge clk);

    pkt_in(0, 0, acc, rc, got);
    chk(!acc, "R3 IN with empty buffer NAKs", int'(acc), 0);

    pkt_out(OE, 10, 3, 0, acc, st);
    chk(acc, "R2 OUT ready when empty", int'(acc), 1);
    pkt_out(OE, 4, 9, 0, acc, st);
    chk(!acc, "R3 OUT with full buffer NAKs", int'(acc), 0);

    expect_pay(10, 3, exp);
    pkt_in(8, 1, acc, rc, got);
    chk(same(got, exp), "R4 payload without check bytes", got.size(), exp.size());
    pkt_in(8, 0, acc, rc, got2);
    chk(same(got2, exp), "R8 resend after error", got2.size(), exp.size());
    pkt_in(0, 0, acc, rc, got);
    chk(!acc, "R9 buffer empty after clean send", int'(acc), 0);

    pkt_out(OE, 6, 40, 1, acc, st);
    chk(acc, "R5 errored OUT was accepted", int'(acc), 1);
    pkt_in(0, 0, acc, rc, got);
    chk(!acc, "R5 errored OUT discarded", int'(acc), 0);

    pkt_out(OE, 2, 77, 0, acc, st);
    pkt_in(0, 0, acc, rc, got);
    chk(acc && rc == 1, "R7 zero-length ready pulse", rc, 1);
    chk(got.size() == 0, "R7 zero-length payload", got.size(), 0);

    pkt_out(3'd5, 4, 1, 0, acc, st);
    chk(!acc, "R2 foreign endpoint ignored", int'(acc), 0);

    pkt_out(OE, MAXP + 2, 11, 0, acc, st);
    expect_pay(MAXP + 2, 11, exp);
    pkt_in(MAXP, 0, acc, rc, got);
    chk(same(got, exp), "R4 full-length payload", got.size(), exp.size());

    pkt_out(OE, MAXP + 3, 5, 0, acc, st);
    pkt_out(OE, 4, 5, 0, acc, st);
    chk(!acc && st, "R10 overrun halts OUT endpoint", int'(st), 1);
    pkt_in(0, 0, acc, rc, got);
    chk(!acc, "R10 overrun packet discarded", int'(acc), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule